// File: doc/BRIEF.md
# Serial Complex Convolution Engine

This block computes one complex-valued output of a Gabor-style image filter. It uses a single multiplier and a single adder, shared in time across every kernel tap. When `start` is low, the engine is in load mode. In load mode, image pixels presented on a write port are stored in an internal pixel memory with one entry per kernel tap.

Raising `start` begins a convolution. A controller then walks the tap index and presents the same index to the pixel memory and to a constant coefficient ROM in lockstep. Each tap is visited twice in a row: first with its real coefficient, then with its imaginary coefficient. This gives one product per cycle into one of two accumulators. With the default 111 taps, a convolution takes 222 product cycles.

When the final product has been added, both sums are registered on the result outputs and a one-cycle `done` pulse is issued. Dropping `start` early abandons the run. A new run needs `start` to fall and rise again.

Top module: `cplx_conv_engine`

## Requirements
- R1: While `start` is low, a cycle with `wr_en` high and `wr_addr` below TAPS (default 111) stores `wr_data` as the pixel for tap `wr_addr`. Pixels are 8-bit unsigned.
- R2: A write presented while `start` is high is ignored. A write with `wr_addr` of TAPS or more is ignored and does not alias onto any stored pixel.
- R3: The coefficient of tap k is a 12-bit two's complement value with 10 fractional bits. The real part is the low 12 bits of (173*k + 29). The imaginary part is the low 12 bits of (91*k + 1000).
- R4: `res_re` is the sum over all taps of pixel(k) times real coefficient(k). `res_im` is the same sum with imaginary coefficient(k). Both are 28-bit two's complement integers in units of 2^-10, with no overflow for any pixel values.
- R5: A convolution starts at the clock edge that samples `start` high after it was low; call this edge 0. The `done` pulse appears in the cycle right after edge 222, with the results valid in that same cycle.
- R6: `done` is high for exactly one cycle. Holding `start` high after a completed run starts no new run and gives no further pulse.
- R7: If `start` is low at any edge before completion, the run is abandoned. No `done` follows and the results keep their previous values. The next rise of `start` begins a full, correct run.
- R8: `res_re` and `res_im` change only in the cycle where `done` is high, and are otherwise held.
- R9: Synchronous active-low reset drives `done` low and both results to zero, and cancels any run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Low: load mode. Rising edge: begin a convolution. Must stay high for the run. |
| wr_en | input | 1 | Pixel write strobe (load mode only) |
| wr_addr | input | 7 | Pixel write address (tap index) |
| wr_data | input | 8 | Unsigned pixel value |
| done | output | 1 | One-cycle completion pulse |
| res_re | output | 28 | Real accumulated result, signed, 10 fractional bits |
| res_im | output | 28 | Imaginary accumulated result, signed, 10 fractional bits |

## Verification
The bench counts cycles from the sampling edge of `start` to `done`. An engine with an extra pipeline register, or one that drops the last imaginary product, would miss 222 or give a wrong `res_im`. It tries writes during a run and at addresses 111 and 127. A design that lets these through, or wraps the address, would change the next result. Early release of `start` and holding `start` high after `done` are both exercised. Designs that finish the run anyway, re-arm by themselves, or fail to clear the accumulators on the next start would pulse `done` when they should not or report sums that include stale data.

// File: rtl/cmac_pkg.sv
// Package cmac_pkg
// Shared constants and the coefficient formulas for the serial complex
// convolution engine. Assumes coefficient widths of at most 31 bits.
package cmac_pkg;

    localparam int DEF_PIX_W  = 8;
    localparam int DEF_COEF_W = 12;
    localparam int DEF_TAPS   = 111;

    // Real coefficient of tap k, reduced to the low coef_w bits.
    function automatic int coef_re_raw(input int k, input int coef_w);
        return (k * 173 + 29) % (1 << coef_w);
    endfunction

    // Imaginary coefficient of tap k, reduced to the low coef_w bits.
    function automatic int coef_im_raw(input int k, input int coef_w);
        return (k * 91 + 1000) % (1 << coef_w);
    endfunction

endpackage

// File: rtl/cmac_ctrl.sv
// Module cmac_ctrl
// Sequencer. It detects the rising edge of start and then steps through
// 2*TAPS product slots. The tap index goes to both memories at once, and
// the low step bit chooses real or imaginary. Assumes start stays high for
// the whole run; a low start at any edge cancels the run.
module cmac_ctrl #(
    parameter int TAPS   = 111,
    parameter int ADDR_W = 7,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              clr,
    output logic              valid,
    output logic              last,
    output logic              sel_im,
    output logic [ADDR_W-1:0] tap
);
    localparam int LAST_STEP = 2 * TAPS - 1;

    logic              start_q;
    logic              busy;
    logic [STEP_W-1:0] step;

    assign clr    = start & ~start_q;
    assign valid  = busy & start;
    assign last   = (step == STEP_W'(LAST_STEP));
    assign sel_im = step[0];
    assign tap    = ADDR_W'(step >> 1);

    // Track start history and advance the product step while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            busy    <= 1'b0;
            step    <= '0;
        end else begin
            start_q <= start;
            if (!start) begin
                busy <= 1'b0;
                step <= '0;
            end else if (clr) begin
                busy <= 1'b1;
                step <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmac_pixmem.sv
// Module cmac_pixmem
// Pixel store with one entry per tap. It has a synchronous write port and
// a combinational read. Writes at or above DEPTH are dropped. The array
// itself is not reset.
module cmac_pixmem #(
    parameter int DEPTH  = 111,
    parameter int ADDR_W = 7,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PIX_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PIX_W-1:0]  rdata
);
    logic [PIX_W-1:0] mem [DEPTH];
    logic             in_range;

    assign in_range = ({1'b0, waddr} < (ADDR_W + 1)'(DEPTH));
    assign rdata    = mem[raddr];

    // Store a pixel when the write is enabled and in range.
    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/cmac_coef_rom.sv
// Module cmac_coef_rom
// Constant complex coefficient table, one entry per tap. It is built
// by a generate loop from the package formulas. It returns the real or
// imaginary part, chosen by sel_im. Assumes addr < TAPS.
module cmac_coef_rom #(
    parameter int TAPS   = 111,
    parameter int ADDR_W = 7,
    parameter int COEF_W = 12
) (
    input  logic              [ADDR_W-1:0] addr,
    input  logic                           sel_im,
    output logic signed       [COEF_W-1:0] coef
);
    logic [COEF_W-1:0] tab_re [TAPS];
    logic [COEF_W-1:0] tab_im [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tab_re[g] = COEF_W'(cmac_pkg::coef_re_raw(g, COEF_W));
        assign tab_im[g] = COEF_W'(cmac_pkg::coef_im_raw(g, COEF_W));
    end

    // Select the requested part of the addressed coefficient.
    always_comb begin
        coef = sel_im ? $signed(tab_im[addr]) : $signed(tab_re[addr]);
    end

endmodule

// File: rtl/cmac_mac.sv
// Module cmac_mac
// The single shared multiplier and adder. Each valid cycle adds one
// product to the real or the imaginary sum. On the last step it
// registers both finished sums and pulses done. Assumes clr and valid
// are never high together.
module cmac_mac #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 12,
    parameter int ACC_W  = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    valid,
    input  logic                    last,
    input  logic                    sel_im,
    input  logic        [PIX_W-1:0] pix,
    input  logic signed [COEF_W-1:0] coef,
    output logic                    done,
    output logic signed [ACC_W-1:0] res_re,
    output logic signed [ACC_W-1:0] res_im
);
    localparam int PRD_W = PIX_W + 1 + COEF_W;

    logic signed [PRD_W-1:0] prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc_re, acc_im;
    logic signed [ACC_W-1:0] sum_re, sum_im;

    assign prod     = $signed({1'b0, pix}) * coef;
    assign prod_ext = {{(ACC_W - PRD_W){prod[PRD_W-1]}}, prod};
    assign sum_re   = acc_re + prod_ext;
    assign sum_im   = acc_im + prod_ext;

    // Clear on a new run, then add one product per valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (valid) begin
            if (sel_im) begin
                acc_im <= sum_im;
            end else begin
                acc_re <= sum_re;
            end
        end
    end

    // Capture the finished sums and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            res_re <= '0;
            res_im <= '0;
        end else begin
            done <= valid & last;
            if (valid && last) begin
                res_re <= sel_im ? acc_re : sum_re;
                res_im <= sel_im ? sum_im : acc_im;
            end
        end
    end

endmodule

// File: rtl/cplx_conv_engine.sv
// Module cplx_conv_engine
// Top of the serial complex convolution engine. With start low it loads
// pixels. A rising start runs 2*TAPS products through one multiplier and
// ends with a done pulse. Assumes start is held high for the whole run.
module cplx_conv_engine #(
    parameter int PIX_W  = cmac_pkg::DEF_PIX_W,
    parameter int COEF_W = cmac_pkg::DEF_COEF_W,
    parameter int TAPS   = cmac_pkg::DEF_TAPS,
    parameter int ADDR_W = $clog2(TAPS),
    parameter int ACC_W  = PIX_W + COEF_W + $clog2(TAPS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [PIX_W-1:0]        wr_data,
    output logic                    done,
    output logic signed [ACC_W-1:0] res_re,
    output logic signed [ACC_W-1:0] res_im
);
    localparam int STEP_W = ADDR_W + 1;

    logic                     clr, valid, last, sel_im;
    logic [ADDR_W-1:0]        tap;
    logic [PIX_W-1:0]         pix;
    logic signed [COEF_W-1:0] coef;
    logic                     load_we;

    assign load_we = wr_en & ~start;

    cmac_ctrl #(.TAPS(TAPS), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .valid(valid),
        .last(last), .sel_im(sel_im), .tap(tap)
    );

    cmac_pixmem #(.DEPTH(TAPS), .ADDR_W(ADDR_W), .PIX_W(PIX_W)) i_pixmem (
        .clk(clk), .we(load_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(tap), .rdata(pix)
    );

    cmac_coef_rom #(.TAPS(TAPS), .ADDR_W(ADDR_W), .COEF_W(COEF_W)) i_rom (
        .addr(tap), .sel_im(sel_im), .coef(coef)
    );

    cmac_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_mac (
        .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .last(last),
        .sel_im(sel_im), .pix(pix), .coef(coef), .done(done),
        .res_re(res_re), .res_im(res_im)
    );

endmodule

// File: rtl/cmac_checker.sv
// Module cmac_checker
// Port-level protocol properties for cplx_conv_engine, attached by bind.
module cmac_checker #(
    parameter int ACC_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [ACC_W-1:0] res_re,
    input logic [ACC_W-1:0] res_im
);
    // R6: the completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a low start at an edge means no done after that edge
    a_r7_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R5: done only follows an edge that saw start high
    a_r5_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    // R8: results move only together with done
    a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(res_re) || !$stable(res_im)) |-> done);

    // R6: the cycle after a start rise never carries done
    a_r6_no_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start) |=> !done);
endmodule

bind cplx_conv_engine cmac_checker #(.ACC_W(ACC_W)) i_cmac_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .res_re(res_re), .res_im(res_im)
);

// File: tb/test_cplx_conv_engine.sv
module test_cplx_conv_engine;
    localparam int TAPS  = 111;
    localparam int ACC_W = 28;
    localparam int NVEC  = 5;
    // pixel pattern: pix(k) = (a*k + b) mod 256, as {a, b}
    localparam int VEC [NVEC][2] = '{'{0, 0}, '{0, 255}, '{1, 0}, '{37, 91}, '{200, 13}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             wr_en = 1'b0;
    logic [6:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             done;
    logic [ACC_W-1:0] res_re, res_im;

    cplx_conv_engine i_cplx_conv_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .res_re(res_re), .res_im(res_im)
    );

    int total = 0;
    int bad = 0;
    int cyc_all = 0;
    int pix_img [TAPS];

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            bad++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc_all);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int cre(input int k);
        int v = (k * 173 + 29) % 4096;
        return (v >= 2048) ? v - 4096 : v;
    endfunction

    function automatic int cim(input int k);
        int v = (k * 91 + 1000) % 4096;
        return (v >= 2048) ? v - 4096 : v;
    endfunction

    function automatic longint exp_sum(input bit im);
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += pix_img[k] * (im ? cim(k) : cre(k));
        return s;
    endfunction

    function automatic longint sres(input logic [ACC_W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Load a full pattern in load mode (R1); called and returns at a negedge.
    task automatic load(input int a, input int b);
        for (int k = 0; k < TAPS; k++) begin
            pix_img[k] = (a * k + b) % 256;
            wr_en = 1'b1;
            wr_addr = 7'(k);
            wr_data = 8'(pix_img[k]);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    // Raise start and count cycles until done; start stays high.
    task automatic run(output int cyc);
        start = 1'b1;
        cyc = -1;
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (done) break;
        end
    endtask

    task automatic full_check(input string tag);
        int cyc;
        run(cyc);
        check({tag, " R5 cycles"}, cyc, 222);
        check({tag, " R4 re"}, sres(res_re), exp_sum(1'b0));
        check({tag, " R4 im"}, sres(res_im), exp_sum(1'b1));
        @(negedge clk);
        check({tag, " R6 single pulse"}, done, 0);
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        longint hold_re, hold_im;
        int seen;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 done in reset", done, 0);
        check("R9 res_re in reset", sres(res_re), 0);
        check("R9 res_im in reset", sres(res_im), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R5 R6: table of pixel patterns
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][0], VEC[v][1]);
            full_check($sformatf("vec%0d", v));
        end

        // R2: out-of-range writes must not alias onto taps
        load(37, 91);
        wr_en = 1'b1; wr_addr = 7'd111; wr_data = 8'd255; @(negedge clk);
        wr_addr = 7'd127; wr_data = 8'd254; @(negedge clk);
        wr_en = 1'b0;
        full_check("R2 range");

        // R2: writes during a run are ignored, now and in the next run
        begin
            int cyc;
            start = 1'b1;
            repeat (10) @(negedge clk);
            wr_en = 1'b1; wr_addr = 7'd0; wr_data = 8'd7; @(negedge clk);
            wr_addr = 7'd5; wr_data = 8'd200; @(negedge clk);
            wr_en = 1'b0;
            cyc = 0;
            while (!done && cyc < 400) begin @(negedge clk); cyc++; end
            check("R2 run write re", sres(res_re), exp_sum(1'b0));
            check("R2 run write im", sres(res_im), exp_sum(1'b1));
            // R6: hold start high, no new pulse, results hold (R8)
            hold_re = sres(res_re); hold_im = sres(res_im);
            seen = 0;
            repeat (300) begin @(negedge clk); if (done) seen++; end
            check("R6 no rerun while high", seen, 0);
            check("R8 hold re", sres(res_re), hold_re);
            check("R8 hold im", sres(res_im), hold_im);
            start = 1'b0;
            @(negedge clk);
        end
        full_check("R2 after run write");

        // R7: abort mid run
        load(200, 13);
        full_check("R7 before");
        hold_re = sres(res_re); hold_im = sres(res_im);
        load(1, 0);
        start = 1'b1;
        repeat (100) @(negedge clk);
        start = 1'b0;
        seen = 0;
        repeat (300) begin @(negedge clk); if (done) seen++; end
        check("R7 no done after abort", seen, 0);
        check("R7 re kept", sres(res_re), hold_re);
        check("R7 im kept", sres(res_im), hold_im);
        full_check("R7 recover");

        // R9: reset during a run
        start = 1'b1;
        repeat (30) @(negedge clk);
        rst_n = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 res_re after reset", sres(res_re), 0);
        check("R9 res_im after reset", sres(res_im), 0);
        rst_n = 1'b1;
        seen = 0;
        repeat (300) begin @(negedge clk); if (done) seen++; end
        check("R9 run cancelled", seen, 0);
        full_check("R9 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule